// File: doc/BRIEF.md
# Loadable Pseudo-Random Byte Generator

This block produces a stream of pseudo-random bytes from an 8-bit linear-feedback shift register in Fibonacci form. Each advance moves the register one place toward its most significant bit. The vacated bit 0 takes the parity of a fixed group of tap bits. The register contents are the random value presented at the output.

A synchronous seed port lets the owner restart the sequence from any chosen value. A seed of zero would lock the register at zero, so it is replaced by a fixed nonzero value. Loading takes priority over advancing. With neither request active, the register keeps its value. The fixed taps give a maximal-length sequence that visits all 255 nonzero bytes before it repeats.

Top module: `lfsr_prng_top`

## Requirements
- R1: While rst_n is low, and on the first clock after it is released, rnd_o equals 8'hFF.
- R2: On a clock with step_i high and load_i low, bits 7..1 of rnd_o take the values that bits 6..0 held before that clock.
- R3: On that same kind of clock, the new bit 0 of rnd_o is the XOR of the prior bits 7, 5, 4 and 3. From 8'hFF the next value is therefore 8'hFE.
- R4: On a clock with load_i high and a nonzero seed_i, rnd_o takes the value of seed_i.
- R5: On a clock with load_i high and seed_i equal to 8'h00, rnd_o becomes 8'h01.
- R6: When load_i and step_i are both high, the load is performed and the step is not.
- R7: On a clock with load_i and step_i both low, rnd_o keeps its value.
- R8: After reset, rnd_o is never 8'h00.
- R9: Starting from any nonzero value, 255 consecutive steps pass through 255 distinct nonzero values and end on the starting value.
- R10: After seed 8'hFF is loaded, the first ten steps produce the values that R2 and R3 give when applied in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Seed-load request |
| seed_i | input | 8 | Seed value used on a load |
| step_i | input | 1 | Advance the sequence one step |
| rnd_o | output | 8 | Current register value (random output) |

## Verification
Every result appears exactly one clock after the request that causes it. The register drives rnd_o directly, with no further stage in between. The bench drives load_i, step_i and seed_i on the falling edge. It reads rnd_o on the next falling edge, half a period after the rising edge that made the change. Each expected value comes from a shift-and-parity model in the bench that is applied once per clock. The bench checks a load response and a step response for all 256 seeds. It walks the full 255-step cycle, checks the hold case and the priority case, and checks the reset value on the first cycle after reset is released.

// File: rtl/lfsr_prng_pkg.sv
package lfsr_prng_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } lfsr_op_e;

    localparam int unsigned DEF_WIDTH = 8;

endpackage

// File: rtl/lfsr_op_decode.sv
module lfsr_op_decode
    import lfsr_prng_pkg::*;
(
    input  logic     load_i,
    input  logic     step_i,
    output lfsr_op_e op_o
);

    always_comb begin
        if (load_i) begin
            op_o = OP_LOAD;
        end else if (step_i) begin
            op_o = OP_STEP;
        end else begin
            op_o = OP_HOLD;
        end
    end

endmodule

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
    parameter int unsigned       WIDTH    = 8,
    parameter logic [WIDTH-1:0]  TAP_MASK = 8'hB8
) (
    input  logic [WIDTH-1:0] state_i,
    output logic             fb_o
);

    logic [WIDTH:0] chain;

    assign chain[0] = 1'b0;

    for (genvar g = 0; g < WIDTH; g++) begin : g_tap
        if (TAP_MASK[g]) begin : g_on
            assign chain[g+1] = chain[g] ^ state_i[g];
        end else begin : g_off
            assign chain[g+1] = chain[g];
        end
    end

    assign fb_o = chain[WIDTH];

endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
    parameter int unsigned      WIDTH      = 8,
    parameter logic [WIDTH-1:0] ZERO_SUBST = 8'h01
) (
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] seed_o
);

    always_comb begin
        if (seed_i == '0) begin
            seed_o = ZERO_SUBST;
        end else begin
            seed_o = seed_i;
        end
    end

endmodule

// File: rtl/lfsr_prng_top.sv
module lfsr_prng_top
    import lfsr_prng_pkg::*;
#(
    parameter int unsigned      WIDTH      = DEF_WIDTH,
    parameter logic [WIDTH-1:0] TAP_MASK   = 8'hB8,
    parameter logic [WIDTH-1:0] RESET_VAL  = 8'hFF,
    parameter logic [WIDTH-1:0] ZERO_SUBST = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic             step_i,
    output logic [WIDTH-1:0] rnd_o
);

    localparam int unsigned MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] val;
    } lfsr_state_t;

    lfsr_state_t      state_d;
    lfsr_state_t      state_q;
    lfsr_op_e         op;
    logic             fb;
    logic [WIDTH-1:0] seed_safe;

    lfsr_op_decode i_decode (
        .load_i (load_i),
        .step_i (step_i),
        .op_o   (op)
    );

    lfsr_feedback #(
        .WIDTH    (WIDTH),
        .TAP_MASK (TAP_MASK)
    ) i_feedback (
        .state_i (state_q.val),
        .fb_o    (fb)
    );

    lfsr_seed_guard #(
        .WIDTH      (WIDTH),
        .ZERO_SUBST (ZERO_SUBST)
    ) i_guard (
        .seed_i (seed_i),
        .seed_o (seed_safe)
    );

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_LOAD: state_d.val = seed_safe;
            OP_STEP: state_d.val = {state_q.val[MSB-1:0], fb};
            default: state_d     = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.val <= RESET_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign rnd_o = state_q.val;

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_o != '0); // R8

    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_i) |=> (rnd_o[MSB:1] == $past(rnd_o[MSB-1:0]))); // R2

    AST_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_i) |=> (rnd_o[0] == ^($past(rnd_o) & TAP_MASK))); // R3

    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i != '0) |=> (rnd_o == $past(seed_i))); // R4

    AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i == '0) |=> (rnd_o == ZERO_SUBST)); // R5

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(rnd_o)); // R7

endmodule

// File: tb/test_lfsr_prng_top.sv
module test_lfsr_prng_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] seed_i = 8'h00;
    logic       step_i = 1'b0;
    logic [7:0] rnd_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    lfsr_prng_top i_lfsr_prng_top (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .seed_i (seed_i),
        .step_i (step_i),
        .rnd_o  (rnd_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] model_next(input logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic ld, input logic st, input logic [7:0] sd);
        load_i = ld;
        step_i = st;
        seed_i = sd;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        logic [7:0] exp;
        logic [7:0] start;
        bit         seen [256];

        // R1: reset value while held and after release
        @(negedge clk);
        @(negedge clk);
        check("R1 held", rnd_o, 8'hFF);
        rst_n = 1'b1;
        cycle(1'b0, 1'b0, 8'h00);
        check("R1 released", rnd_o, 8'hFF);

        // R3: first step from FF gives FE
        cycle(1'b0, 1'b1, 8'h00);
        check("R3 FF->FE", rnd_o, 8'hFE);

        // R4 R5 R2 R3: every seed, then one step
        for (int s = 0; s < 256; s++) begin
            cycle(1'b1, 1'b0, 8'(s));
            exp = (s == 0) ? 8'h01 : 8'(s);
            check(s == 0 ? "R5 zero seed" : "R4 seed load", rnd_o, exp);
            cycle(1'b0, 1'b1, 8'h00);
            exp = model_next(exp);
            check("R2 R3 step after load", rnd_o, exp);
        end

        // R7: hold for several idle cycles
        cycle(1'b1, 1'b0, 8'h5A);
        for (int k = 0; k < 5; k++) begin
            cycle(1'b0, 1'b0, 8'hC3);
            check("R7 hold", rnd_o, 8'h5A);
        end

        // R6: load wins over step
        cycle(1'b1, 1'b1, 8'h3C);
        check("R6 load priority", rnd_o, 8'h3C);
        cycle(1'b1, 1'b1, 8'h00);
        check("R6 R5 zero load priority", rnd_o, 8'h01);

        // R10: ten values after seed FF
        cycle(1'b1, 1'b0, 8'hFF);
        exp = 8'hFF;
        for (int k = 0; k < 10; k++) begin
            cycle(1'b0, 1'b1, 8'h00);
            exp = model_next(exp);
            check("R10 first ten", rnd_o, exp);
        end

        // R9 R8: full period from two starting values
        for (int p = 0; p < 2; p++) begin
            start = (p == 0) ? 8'hFF : 8'h01;
            cycle(1'b1, 1'b0, start);
            for (int v = 0; v < 256; v++) seen[v] = 1'b0;
            exp = start;
            for (int k = 1; k <= 255; k++) begin
                cycle(1'b0, 1'b1, 8'h00);
                exp = model_next(exp);
                if (rnd_o === 8'h00) check("R8 nonzero", rnd_o, 8'hFF);
                if (k < 255 && rnd_o === start) check("R9 early return", rnd_o, ~start);
                if (seen[rnd_o]) check("R9 repeat", rnd_o, ~rnd_o);
                seen[rnd_o] = 1'b1;
                if (k == 255) check("R9 period", rnd_o, start);
                else if (rnd_o !== exp) check("R9 sequence", rnd_o, exp);
            end
            checks++;
        end

        finish_run();
    end

endmodule